// File: doc/BRIEF.md
# Address Lock Table

This block keeps a small associative table of memory addresses that software threads currently hold locked. Each request carries an operation code and an address. A lock request succeeds only when the address is free and a slot remains. A release removes the address if it is present. A release-with-write does the same and also forwards a write of that address to the memory side. A counter of outstanding locks shows how full the table is and points at the next free slot.

A release naming an address that is not held is harmless. The counter and the table stay as they were, and a release-with-write reduces to a plain write. This keeps the bookkeeping exact however threads behave, so a lock on a free address cannot be refused because of an earlier stray release. Entries are kept dense: a release moves the last valid entry into the freed slot. The block accepts one request per cycle and answers in the following cycle.

Top module: `lock_table`

## Requirements
- R1: After reset the lock count is 0, `table_full` is 0, and `rsp_valid` and `mem_wr_valid` are 0.
- R2: A lock request (`req_op` = 0) for an address not in the table, made while the count is below ENTRIES, gives `rsp_valid`=1, `rsp_ok`=1 and `rsp_hit`=0 in the next cycle, and the count rises by one.
- R3: A lock request for an address already in the table gives `rsp_ok`=0 and `rsp_hit`=1 in the next cycle and leaves the count unchanged.
- R4: A lock request made while the count equals ENTRIES gives `rsp_ok`=0 and leaves the count unchanged. `table_full` is 1 exactly when the count equals ENTRIES.
- R5: A release (`req_op` = 1) of an address in the table gives `rsp_ok`=1 and `rsp_hit`=1 in the next cycle and lowers the count by one. A later lock request for that address succeeds.
- R6: A release of an address not in the table gives `rsp_ok`=0 and `rsp_hit`=0 and changes neither the count nor the set of locked addresses.
- R7: A release-with-write (`req_op` = 2) raises `mem_wr_valid` for one cycle in the next cycle, with `mem_wr_addr` equal to the request address. If the address is held, it is also released as in R5.
- R8: A release-with-write of an address not in the table only performs the write. The count and the locked set stay unchanged, and `rsp_ok`=0.
- R9: After any release, every address that remains locked still refuses a lock request, and the count equals the number of locked addresses.
- R10: The count never exceeds ENTRIES. Operation code 3, or `req_valid`=0, produces no response, no write and no state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 lock, 1 release, 2 release-with-write, 3 no operation |
| req_addr | input | AW | Address of the request |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_ok | output | 1 | Lock granted, or release found its address |
| rsp_hit | output | 1 | Address was in the table when the request arrived |
| mem_wr_valid | output | 1 | Write forwarded to memory |
| mem_wr_addr | output | AW | Address of the forwarded write |
| lock_count | output | $clog2(ENTRIES+1) | Number of outstanding locks |
| table_full | output | 1 | Count equals ENTRIES |

## Verification
The bench builds the block with ENTRIES=4 and AW=6. Four slots fill within a few requests, so a full table, refusals while full, and compaction after removing the first, a middle or the last slot all come up often. A pool of ten addresses in a six-bit space mixes stray releases and writes with releases of held addresses. Random traffic can then drive the counter through every value from empty to full many times.

// File: rtl/lock_table_pkg.sv
package lock_table_pkg;

  typedef enum logic [1:0] {
    OP_READ_LOCK    = 2'd0,
    OP_UNLOCK       = 2'd1,
    OP_WRITE_UNLOCK = 2'd2,
    OP_NONE         = 2'd3
  } lock_op_e;

  // Occupancy after one cycle: a grant adds a slot, a release frees one.
  function automatic int unsigned count_after(int unsigned cur, logic take, logic give);
    int unsigned nxt;
    nxt = cur;
    if (take) nxt = nxt + 1;
    if (give) nxt = nxt - 1;
    return nxt;
  endfunction

  // Full when the occupancy reached capacity.
  function automatic logic at_capacity(int unsigned cur, int unsigned cap);
    return cur >= cap;
  endfunction

endpackage

// File: rtl/lock_match.sv
module lock_match #(
  parameter int ENTRIES = 8,
  parameter int AW      = 24,
  parameter int IW      = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][AW-1:0]    addrs,
  input  logic [AW-1:0]                 key,
  output logic                          hit,
  output logic [IW-1:0]                 hit_idx
);

  logic [ENTRIES-1:0] match_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid[g] && (addrs[g] == key);
  end

  assign hit = |match_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) hit_idx = IW'(i);
    end
  end

  // R3
  uniq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

endmodule

// File: rtl/lock_store.sv
module lock_store
  import lock_table_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW      = 24,
  parameter int IW      = 3,
  parameter int CW      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ins_en,
  input  logic [AW-1:0]                 ins_addr,
  input  logic                          rem_en,
  input  logic [IW-1:0]                 rem_idx,
  output logic [ENTRIES-1:0]            valid,
  output logic [ENTRIES-1:0][AW-1:0]    addrs,
  output logic [CW-1:0]                 count
);

  logic [ENTRIES-1:0]         valid_q;
  logic [ENTRIES-1:0][AW-1:0] addrs_q;
  logic [CW-1:0]              cnt_q;
  logic [CW-1:0]              cnt_m1;
  logic [IW-1:0]              tail_idx;
  logic [IW-1:0]              free_idx;

  assign cnt_m1   = cnt_q - CW'(1);
  assign tail_idx = cnt_m1[IW-1:0];
  assign free_idx = cnt_q[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      addrs_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (ins_en) begin
        addrs_q[free_idx] <= ins_addr;
        valid_q[free_idx] <= 1'b1;
      end
      if (rem_en) begin
        addrs_q[rem_idx]  <= addrs_q[tail_idx];
        valid_q[tail_idx] <= 1'b0;
      end
      cnt_q <= CW'(count_after(32'(cnt_q), ins_en, rem_en));
    end
  end

  assign valid = valid_q;
  assign addrs = addrs_q;
  assign count = cnt_q;

  // R9
  dense_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q) == int'(cnt_q));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(ENTRIES));

  // R4
  no_ins_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> cnt_q < CW'(ENTRIES));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rem_en |-> cnt_q != '0);

endmodule

// File: rtl/lock_table.sv
module lock_table
  import lock_table_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW      = 24,
  localparam int CW     = $clog2(ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic          rsp_hit,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [CW-1:0] lock_count,
  output logic          table_full
);

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  lock_op_e                   op;
  logic [ENTRIES-1:0]         valid;
  logic [ENTRIES-1:0][AW-1:0] addrs;
  logic                       hit;
  logic [IW-1:0]              hit_idx;

  // Named internal events
  logic ev_read_lock, ev_unlock, ev_write_unlock, ev_any;
  logic ev_grant, ev_deny, ev_release, ev_stray;

  assign op = lock_op_e'(req_op);

  assign table_full      = at_capacity(32'(lock_count), ENTRIES);
  assign ev_read_lock    = req_valid && (op == OP_READ_LOCK);
  assign ev_unlock       = req_valid && (op == OP_UNLOCK);
  assign ev_write_unlock = req_valid && (op == OP_WRITE_UNLOCK);
  assign ev_any          = ev_read_lock || ev_unlock || ev_write_unlock;
  assign ev_grant        = ev_read_lock && !hit && !table_full;
  assign ev_deny         = ev_read_lock && !ev_grant;
  assign ev_release      = (ev_unlock || ev_write_unlock) && hit;
  assign ev_stray        = (ev_unlock || ev_write_unlock) && !hit;

  lock_match #(.ENTRIES(ENTRIES), .AW(AW), .IW(IW)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (valid),
    .addrs   (addrs),
    .key     (req_addr),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  lock_store #(.ENTRIES(ENTRIES), .AW(AW), .IW(IW), .CW(CW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_en   (ev_grant),
    .ins_addr (req_addr),
    .rem_en   (ev_release),
    .rem_idx  (hit_idx),
    .valid    (valid),
    .addrs    (addrs),
    .count    (lock_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_ok       <= 1'b0;
      rsp_hit      <= 1'b0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
    end else begin
      rsp_valid    <= ev_any;
      rsp_ok       <= ev_grant || ev_release;
      rsp_hit      <= ev_any && hit;
      mem_wr_valid <= ev_write_unlock;
      if (ev_write_unlock) mem_wr_addr <= req_addr;
    end
  end

  // R2
  grant_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_grant |=> rsp_ok && (lock_count == $past(lock_count) + CW'(1)));

  // R3
  relock_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_read_lock && hit) |=> !rsp_ok && rsp_hit && $stable(lock_count));

  // R4
  full_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_read_lock && table_full) |=> !rsp_ok && $stable(lock_count));

  // R5
  release_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> rsp_ok && (lock_count == $past(lock_count) - CW'(1)));

  // R6
  stray_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stray |=> !rsp_ok && !rsp_hit && $stable(lock_count) && $stable(valid));

  // R7
  wr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write_unlock |=> mem_wr_valid && (mem_wr_addr == $past(req_addr)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_any |=> !rsp_valid && !mem_wr_valid && $stable(lock_count));

  // R2
  deny_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_deny |=> !rsp_ok);

endmodule

// File: tb/tb_lock_table.sv
module tb_lock_table;

  localparam int N  = 4;
  localparam int W  = 6;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [W-1:0]  req_addr = '0;
  logic          rsp_valid, rsp_ok, rsp_hit, mem_wr_valid, table_full;
  logic [W-1:0]  mem_wr_addr;
  logic [CW-1:0] lock_count;

  always #4 clk = ~clk;

  lock_table #(.ENTRIES(N), .AW(W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_hit(rsp_hit), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .lock_count(lock_count), .table_full(table_full)
  );

  int    total = 0;
  int    fails = 0;
  bit    done  = 1'b0;
  int    held[$];
  bit    have_exp = 1'b0;
  bit    e_rv, e_ok, e_hit, e_wv;
  int    e_wa, e_cnt;
  string e_tag;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("[TB] FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int find_held(int a);
    foreach (held[i]) if (held[i] == a) return i;
    return -1;
  endfunction

  task automatic compare_outputs();
    if (!have_exp) return;
    chk(e_tag, "rsp_valid", int'(rsp_valid), int'(e_rv));
    if (e_rv) begin
      chk(e_tag, "rsp_ok", int'(rsp_ok), int'(e_ok));
      chk(e_tag, "rsp_hit", int'(rsp_hit), int'(e_hit));
    end
    chk(e_tag, "mem_wr_valid", int'(mem_wr_valid), int'(e_wv));
    if (e_wv) chk(e_tag, "mem_wr_addr", int'(mem_wr_addr), e_wa);
    chk(e_tag, "lock_count", int'(lock_count), e_cnt);
    chk("R4", "table_full", int'(table_full), int'(e_cnt == N));
  endtask

  // One clock: check last cycle's outcome, then drive and predict the next.
  task automatic step(bit v, int op, int a, string tag);
    int idx;
    @(negedge clk);
    compare_outputs();
    req_valid = v;
    req_op    = 2'(op);
    req_addr  = W'(a);
    idx  = find_held(a);
    e_rv = 0; e_ok = 0; e_hit = 0; e_wv = 0; e_wa = a;
    if (v && op != 3) begin
      e_rv  = 1;
      e_hit = (idx >= 0);
      if (op == 0) begin
        if (idx < 0 && held.size() < N) begin
          e_ok = 1; held.push_back(a); e_tag = "R2";
        end else e_tag = (idx >= 0) ? "R3" : "R4";
      end else begin
        e_wv = (op == 2);
        if (idx >= 0) begin
          e_ok = 1; held.delete(idx); e_tag = (op == 2) ? "R7" : "R5";
        end else e_tag = (op == 2) ? "R8" : "R6";
      end
    end else e_tag = "R10";
    if (tag != "") e_tag = tag;
    e_cnt    = held.size();
    have_exp = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "lock_count", int'(lock_count), 0);
    chk("R1", "table_full", int'(table_full), 0);
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "mem_wr_valid", int'(mem_wr_valid), 0);

    step(1, 0, 5, "R2");
    step(1, 0, 5, "R3");
    step(1, 1, 9, "R6");
    step(1, 2, 9, "R8");
    step(1, 0, 7, "R2");
    step(1, 0, 11, "R2");
    step(1, 0, 13, "R2");
    step(1, 0, 20, "R4");
    step(1, 1, 7, "R9");
    step(1, 0, 5, "R9");
    step(1, 0, 11, "R9");
    step(1, 0, 13, "R9");
    step(1, 0, 7, "R5");
    step(1, 2, 5, "R7");
    step(1, 3, 11, "R10");
    step(0, 0, 13, "R10");
    step(1, 1, 13, "R9");
    step(1, 0, 11, "R9");
    step(1, 1, 40, "R6");
    step(1, 0, 40, "R6");

    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 9);
      int a = $urandom_range(0, 2 * N + 1);
      int op = (r < 5) ? 0 : (r < 7) ? 1 : (r < 9) ? 2 : 3;
      step(r != 9 || (k % 2 == 0), op, a, "");
    end
    step(0, 0, 0, "");
    @(negedge clk);
    compare_outputs();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("[TB] FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", total, fails);
      $finish;
    end
  end

endmodule